// File: doc/BRIEF.md
# Fine Horizontal Pixel Panning Shifter

This block sits between the display-memory fetch and the colour lookup of a planar 16-colour graphics pipeline. Each fetch delivers one byte from every bit plane, eight pixels wide. The block serialises those bytes into one 4-bit pixel per clock. It can shift the image left by 0 to 7 pixels within a byte. Coarse panning, by whole bytes, stays with the fetch address logic. The fine shift is done here. The shifter keeps two consecutive bytes in a window, so a shifted pixel can take its bits from the byte that follows.

The pan value is sampled only on the rising edge of vertical sync, so a new setting first applies to the next frame. At every line start the block fixes the shift for the whole scan line. When the split-screen region is on display and the suppression control is set, the shift for that line is forced to zero. The split region begins at address zero and is never coarse-panned, so without suppression a fine pan would jitter it. With suppression clear, split lines use the same shift as the upper region.

Top module: `fpan_shifter`

## Requirements
- R1: After reset, `pix_valid` and `pix` are 0 and the latched pan is 0. A line started before any rising edge of `vsync` is serialised with no shift.
- R2: Plane p of a fetch is `fetch_bytes[8p+7:8p]`. Within a byte, bit 7 is the leftmost pixel. The output pixel value has bit p taken from plane p.
- R3: With effective shift s, the valid output of a line is the continuous pixel sequence of that line starting at pixel index s (pixel 0 = bit 7 of the first byte). Pixels cross byte boundaries and take bits from the following byte.
- R4: Count the clock edge that samples `line_start` as edge 0. `pix_valid` is low after edges 0 to 8 of the line and high from edge 9 onward. The pixel after edge 9+k is line pixel k+s. Fetch strobes come every 8 cycles, starting with the `line_start` cycle.
- R5: `pan_in` is latched only at the clock edge where `vsync` is sampled high after being low. Changes to `pan_in` at any other time, including while `vsync` stays high, have no effect.
- R6: The effective shift is chosen at the `line_start` edge and held for the whole line. Changes to `split_active` or `suppress_en` later in the line have no effect on it.
- R7: If `split_active` and `suppress_en` are both 1 at the line start, the line is serialised with shift 0.
- R8: If `split_active` is 1 but `suppress_en` is 0 at the line start, the line uses the latched pan, the same as the upper region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | First cycle of a scan line; coincides with the first fetch strobe |
| fetch_stb | input | 1 | A new byte set is present on `fetch_bytes` |
| fetch_bytes | input | 32 | One byte per plane, plane p at bits 8p+7:8p |
| vsync | input | 1 | Vertical sync level; its rising edge latches the pan |
| pan_in | input | 3 | Requested fine shift, 0 to 7 |
| suppress_en | input | 1 | Force a zero shift on split-screen lines |
| split_active | input | 1 | The line being started belongs to the split region |
| pix | output | 4 | Serialised pixel, bit p from plane p |
| pix_valid | output | 1 | `pix` carries a pixel of the current line |

## Verification
The per-line shift decision and the pan latch each take effect at the edge that samples their trigger. Their results therefore appear in the pixel stream only once the window has filled. The first valid pixel is due after the ninth edge following the line-start edge, and each later edge brings the next pixel. The reference model counts edges from the line start, expects a low `pix_valid` for edges 0 to 8, and then expects line pixel k+s after edge 9+k. The bench drives inputs on the falling edge and reads the outputs of the previous rising edge on the same falling edge. Pixels are compared only while the line's fetched bytes still cover the shifted window. Every pan value is exercised, with suppression both on and off, on upper-region and split lines.

// File: rtl/fpan_pkg.sv
// Shared definitions for the fine-pan shifter.
// Assumes: one fetch strobe per byte time, the first one on line_start.
package fpan_pkg;

    // How many byte sets the two-byte window holds for the current line.
    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_ONE   = 2'd1,
        FILL_FULL  = 2'd2
    } fill_t;

endpackage

// File: rtl/fpan_pan_ctrl.sv
// Pan control: latches the requested shift on the rising edge of vertical
// sync and picks the effective shift for each scan line at line start.
// Assumes: vsync is synchronous to clk.
module fpan_pan_ctrl #(
    parameter int PAN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync,
    input  logic [PAN_W-1:0] pan_in,
    input  logic             line_start,
    input  logic             split_active,
    input  logic             suppress_en,
    output logic [PAN_W-1:0] eff_pan
);

    logic             vsync_q;
    logic [PAN_W-1:0] pan_hold;
    logic             vs_rise;

    assign vs_rise = vsync & ~vsync_q;

    // Remember last vsync level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) vsync_q <= 1'b0;
        else        vsync_q <= vsync;
    end

    // Frame-boundary pan latch.
    always_ff @(posedge clk) begin
        if (!rst_n)       pan_hold <= '0;
        else if (vs_rise) pan_hold <= pan_in;
    end

    // Per-line shift choice, zero on suppressed split lines.
    always_ff @(posedge clk) begin
        if (!rst_n)
            eff_pan <= '0;
        else if (line_start)
            eff_pan <= (split_active && suppress_en) ? '0 : pan_hold;
    end

    assert_pan_only_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(vsync && !vsync_q) |=> $stable(pan_hold));

    assert_line_shift_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(eff_pan));

    assert_split_suppressed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && split_active && suppress_en) |=> (eff_pan == '0));

endmodule

// File: rtl/fpan_window.sv
// Two-byte window per plane plus the pixel phase inside the newer byte time.
// Assumes: fetch strobes are spaced exactly PIX cycles apart within a line.
module fpan_window
    import fpan_pkg::*;
#(
    parameter int PLANES = 4,
    parameter int PIX    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    line_start,
    input  logic                    fetch_stb,
    input  logic [PLANES*PIX-1:0]   byte_in,
    output logic [PLANES*PIX-1:0]   win_hi,
    output logic [PLANES*PIX-1:0]   win_lo,
    output logic [$clog2(PIX)-1:0]  phase,
    output logic                    full
);

    fill_t fill;

    // Shift the window by one byte set on each fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_hi <= '0;
            win_lo <= '0;
        end else if (fetch_stb) begin
            win_hi <= win_lo;
            win_lo <= byte_in;
        end
    end

    // Pixel phase counts cycles since the last fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)                       phase <= '0;
        else if (fetch_stb || line_start) phase <= '0;
        else                              phase <= phase + 1'b1;
    end

    // Track how many bytes of the current line are held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill <= FILL_EMPTY;
        else if (line_start)
            fill <= fetch_stb ? FILL_ONE : FILL_EMPTY;
        else if (fetch_stb)
            fill <= (fill == FILL_EMPTY) ? FILL_ONE : FILL_FULL;
    end

    assign full = (fill == FILL_FULL);

    assert_new_line_not_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !full);

endmodule

// File: rtl/fpan_select.sv
// Per-plane pixel pick from the window at offset phase+shift, registered.
// Assumes: phase + shift never exceeds 2*PIX-2.
module fpan_select #(
    parameter int PLANES = 4,
    parameter int PIX    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   line_start,
    input  logic                   full,
    input  logic [PLANES*PIX-1:0]  win_hi,
    input  logic [PLANES*PIX-1:0]  win_lo,
    input  logic [$clog2(PIX)-1:0] phase,
    input  logic [$clog2(PIX)-1:0] eff_pan,
    output logic [PLANES-1:0]      pix,
    output logic                   pix_valid
);

    localparam int PW = $clog2(PIX);
    localparam int IW = PW + 1;

    logic [IW-1:0]     idx;
    logic [PLANES-1:0] pix_next;

    assign idx = {1'b0, phase} + {1'b0, eff_pan};

    for (genvar gp = 0; gp < PLANES; gp++) begin : g_plane
        logic [2*PIX-1:0] pair;
        logic [2*PIX-1:0] shifted;
        assign pair          = {win_hi[gp*PIX +: PIX], win_lo[gp*PIX +: PIX]};
        assign shifted       = pair << idx;
        assign pix_next[gp]  = shifted[2*PIX-1];
    end

    // Output register for pixel and its qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix       <= '0;
            pix_valid <= 1'b0;
        end else begin
            pix       <= pix_next;
            pix_valid <= full & ~line_start;
        end
    end

    assert_line_start_blanks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !pix_valid);

    assert_first_pixel_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_valid) |-> (phase == 1));

endmodule

// File: rtl/fpan_shifter.sv
// Top: fine horizontal pixel panning shifter for planar pixel data.
// Assumes: line_start carries the first fetch strobe; strobes every PIX cycles.
module fpan_shifter #(
    parameter int PLANES        = 4,
    parameter int PIX_PER_BYTE  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              line_start,
    input  logic                              fetch_stb,
    input  logic [PLANES*PIX_PER_BYTE-1:0]    fetch_bytes,
    input  logic                              vsync,
    input  logic [$clog2(PIX_PER_BYTE)-1:0]   pan_in,
    input  logic                              suppress_en,
    input  logic                              split_active,
    output logic [PLANES-1:0]                 pix,
    output logic                              pix_valid
);

    localparam int PW = $clog2(PIX_PER_BYTE);

    logic [PW-1:0]                   eff_pan;
    logic [PLANES*PIX_PER_BYTE-1:0]  win_hi;
    logic [PLANES*PIX_PER_BYTE-1:0]  win_lo;
    logic [PW-1:0]                   phase;
    logic                            full;

    fpan_pan_ctrl #(.PAN_W(PW)) u_pan (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .pan_in(pan_in),
        .line_start(line_start), .split_active(split_active),
        .suppress_en(suppress_en), .eff_pan(eff_pan)
    );

    fpan_window #(.PLANES(PLANES), .PIX(PIX_PER_BYTE)) u_win (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .fetch_stb(fetch_stb), .byte_in(fetch_bytes),
        .win_hi(win_hi), .win_lo(win_lo), .phase(phase), .full(full)
    );

    fpan_select #(.PLANES(PLANES), .PIX(PIX_PER_BYTE)) u_sel (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .full(full),
        .win_hi(win_hi), .win_lo(win_lo), .phase(phase), .eff_pan(eff_pan),
        .pix(pix), .pix_valid(pix_valid)
    );

endmodule

// File: tb/test_fpan_shifter.sv
module test_fpan_shifter;

    localparam int NB = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic        fetch_stb = 1'b0;
    logic [31:0] fetch_bytes = '0;
    logic        vsync = 1'b0;
    logic [2:0]  pan_in = '0;
    logic        suppress_en = 1'b0;
    logic        split_active = 1'b0;
    logic [3:0]  pix;
    logic        pix_valid;

    int n_checks = 0;
    int n_fail = 0;
    int model_pan = 0;
    logic [31:0] seed = 32'h1234_5678;
    logic [31:0] lb [NB];
    bit done = 0;

    always #10 clk = ~clk;

    fpan_shifter i_fpan_shifter (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .fetch_stb(fetch_stb),
        .fetch_bytes(fetch_bytes), .vsync(vsync), .pan_in(pan_in),
        .suppress_en(suppress_en), .split_active(split_active),
        .pix(pix), .pix_valid(pix_valid)
    );

    function automatic logic [31:0] nxt(input logic [31:0] v);
        logic [31:0] x = v;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference pixel x of the current line (R2 mapping).
    function automatic logic [3:0] ref_pix(input int x);
        logic [3:0] v;
        for (int p = 0; p < 4; p++) v[p] = lb[x/8][p*8 + (7 - x%8)];
        return v;
    endfunction

    task automatic frame_sync(input int pv);
        @(negedge clk); pan_in = 3'(pv); vsync = 1'b1;
        @(negedge clk); pan_in = 3'(~pv);         // R5: no edge, ignored
        @(negedge clk); pan_in = 3'(pv + 3);
        @(negedge clk); vsync = 1'b0; pan_in = 3'(pv + 5); // R5: ignored
        model_pan = pv;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_line(input bit split, input bit supp, input string tag);
        int s;
        s = (split && supp) ? 0 : model_pan;
        for (int j = 0; j < NB; j++) begin seed = nxt(seed); lb[j] = seed; end
        for (int t = 0; t <= 8*NB + 2; t++) begin
            @(negedge clk);
            if (t > 0) begin
                int tt;
                tt = t - 1;
                if (tt < 9) chk("R4 blank", {31'b0, pix_valid}, 32'd0);
                else if (tt - 9 < 8*(NB-1)) begin
                    chk("R4 valid", {31'b0, pix_valid}, 32'd1);
                    chk(tag, {28'b0, pix}, {28'b0, ref_pix(tt - 9 + s)});
                end
            end
            line_start = (t == 0);
            fetch_stb  = (t % 8 == 0) && (t / 8 < NB);
            seed = nxt(seed);
            fetch_bytes = fetch_stb ? lb[t/8] : seed;
            // R6: after the line-start edge, flip region controls
            split_active = (t == 0) ? split : ~split;
            suppress_en  = (t == 0) ? supp  : ~supp;
        end
        @(negedge clk);
        line_start = 0; fetch_stb = 0; split_active = 0; suppress_en = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        pan_in = 3'd5;
        repeat (3) @(negedge clk);
        chk("R1 valid", {31'b0, pix_valid}, 32'd0);
        chk("R1 pix", {28'b0, pix}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid", {31'b0, pix_valid}, 32'd0);
        // R1/R5: pan_in set but no vsync edge yet, shift stays 0
        run_line(1'b0, 1'b0, "R1/R5 R2");
        for (int pv = 0; pv < 8; pv++) begin
            for (int sp = 0; sp < 2; sp++) begin
                frame_sync(pv);
                run_line(1'b0, sp[0], (pv == 0) ? "R2/R6" : "R3/R6");
                run_line(1'b1, sp[0], sp[0] ? "R7/R6" : "R8/R6");
            end
        end
        // R5: vsync held high with new pan value must not relatch
        frame_sync(6);
        @(negedge clk); vsync = 1'b1; pan_in = 3'd6;
        @(negedge clk); vsync = 1'b1; pan_in = 3'd2;
        @(negedge clk); pan_in = 3'd1;
        run_line(1'b0, 1'b0, "R5");
        @(negedge clk); vsync = 1'b0;
        finish_run();
    end

endmodule